// File: doc/BRIEF.md
# Nine-Bit Multidrop Bus UART

This block is an asynchronous serial transceiver for a half-duplex multidrop bus on which every character carries a ninth flag bit. The flag marks a character as a node address (flag set) or as payload (flag clear). The frame is a standard 8-bit character with a parity slot, and the flag travels in that slot. On the transmit side the parity generator runs in forced (stick) mode, so the slot holds a chosen constant instead of a computed parity. On the receive side the parity checker runs in even mode. The flag is then rebuilt from the computed parity and the mismatch status.

A host starts a message with one pulse and a node address. It then hands over payload bytes through a valid/ready handshake and marks the final one. The block sends the address with the flag set, then the payload with the flag clear, and closes with the reserved terminator (0xFF, flag set). It drives a direction line for an RS-485 line driver around the whole message. While that line is asserted the receiver is held idle.

Each received character is delivered in one cycle together with its ninth bit and its parity, framing and break flags. An optional filter delivers only the payload addressed to a programmed node.

Top module: `nbit_bus_uart`

## Requirements
- R1: Each transmitted character is one low start bit, 8 data bits LSB first, one parity slot and one high stop bit. Each bit lasts 16 ticks of TICK_DIV clocks, and `txd` idles high.
- R2: The parity slot of a transmitted character holds the ninth flag: 1 for the address and the terminator, 0 for payload. The slot comes from forced parity that sends the inverse of the even-select control.
- R3: A message is sent in a fixed order: the address latched at `msg_go`, then each byte accepted on `dat_valid && dat_ready`, then 0xFF with the flag set after the byte marked by `dat_last`. A payload byte of 0xFF is sent with the flag clear.
- R4: `rts` rises at least one bit time (16·TICK_DIV clocks) before the first start bit. It stays high until the terminator's stop bit has been fully shifted out. `txd` is high whenever `rts` is low.
- R5: A low level on `rxd` starts a receive frame only if the line is still low at mid start bit. Shorter low pulses deliver nothing.
- R6: `rx_ninth` is the received parity-slot value, rebuilt as the even parity of the data (XOR of its 8 bits), inverted when `rx_perr` is set. `rx_perr` is 1 when the slot differs from that even parity.
- R7: `rx_ferr` is 1 when the stop bit samples low. `rx_brk` is 1 when the data, the slot and the stop bit are all low. Both flags come in the same single-cycle `rx_valid` pulse as their byte.
- R8: While `rts` is high, activity on `rxd` delivers nothing. Reception works again once `rts` falls.
- R9: With `filt_en` low every character is delivered. With `filt_en` high only flag-clear bytes are delivered, and only those that follow a flag-set byte equal to `node_addr`. A non-matching address or the terminator (0xFF, flag set) stops delivery, and no flag-set byte is delivered.
- R10: After reset `rts`=0, `txd`=1, `rx_valid`=0 and `dat_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_go | input | 1 | Pulse that starts a message when idle |
| msg_addr | input | 8 | Destination node address, latched at `msg_go` |
| dat_valid | input | 1 | Payload byte offered |
| dat_byte | input | 8 | Payload byte |
| dat_last | input | 1 | Offered byte is the final payload byte |
| dat_ready | output | 1 | Payload byte taken this cycle if valid |
| txd | output | 1 | Serial transmit line |
| rts | output | 1 | Line-driver enable (direction) |
| rxd | input | 1 | Serial receive line (asynchronous) |
| filt_en | input | 1 | Enable node-address filtering |
| node_addr | input | 8 | This node's address for the filter |
| rx_valid | output | 1 | One-cycle pulse: received character available |
| rx_byte | output | 8 | Received data byte |
| rx_ninth | output | 1 | Recovered ninth (address) flag |
| rx_perr | output | 1 | Parity slot differs from even parity |
| rx_ferr | output | 1 | Stop bit sampled low |
| rx_brk | output | 1 | Break: data, slot and stop all low |

## Verification
The bench builds the block with TICK_DIV=2, so one bit is 32 clocks and a full character 352. At that rate whole messages, the one-bit lead of `rts`, the release after the terminator, and a receive frame sent in the middle of a transmission all fit into a few thousand cycles. The short bit also makes a sub-half-bit glitch a matter of a handful of clocks, so the mid-start-bit qualification is tested at its edge. Sub-bit placement is accurate to within one tick, so each check samples at mid bit.

// File: rtl/nbit_pkg.sv
package nbit_pkg;
    localparam int OSR        = 16;
    localparam int OSR_W      = $clog2(OSR);
    localparam int OSR_MID    = OSR / 2 - 1;
    localparam int FRAME_MAX  = 11;
    localparam int FRAME_W    = $clog2(FRAME_MAX);
    localparam int RX_SAMPLES = 9;
    localparam int LEAD_TICKS = OSR + 1;
    localparam int LEAD_W     = $clog2(LEAD_TICKS + 1);
    localparam logic [7:0] TERM_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_LEAD, SQ_ADDR, SQ_DATA, SQ_TERM, SQ_DRAIN
    } seq_e;

    typedef enum logic [2:0] {
        RS_IDLE, RS_START, RS_BITS, RS_STOP, RS_WAITHI
    } rxs_e;

    typedef struct packed {
        logic [7:0] data;
        logic       slot;
        logic       stop;
    } rx_frame_t;
endpackage

// File: rtl/nbit_tick.sv
module nbit_tick #(
    parameter int TICK_DIV = 68
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == TOP) d.cnt = '0;
        else              d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = (q.cnt == TOP);
endmodule

// File: rtl/nbit_tx_ser.sv
module nbit_tx_ser
    import nbit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       ld_i,
    input  logic [7:0] ld_data_i,
    input  logic       par_en_i,
    input  logic       stick_i,
    input  logic       even_sel_i,
    output logic       busy_o,
    output logic       txd_o
);
    typedef struct packed {
        logic                 busy;
        logic [FRAME_MAX-1:0] sh;
        logic [OSR_W-1:0]     tcnt;
        logic [FRAME_W-1:0]   bits;
        logic [FRAME_W-1:0]   last;
    } ser_t;

    ser_t q, d;
    logic slot;

    always_comb begin
        if (stick_i)         slot = ~even_sel_i;
        else if (even_sel_i) slot = ^ld_data_i;
        else                 slot = ~(^ld_data_i);

        d = q;
        if (!q.busy) begin
            if (ld_i) begin
                d.busy = 1'b1;
                d.tcnt = '0;
                d.bits = '0;
                if (par_en_i) begin
                    d.sh   = {1'b1, slot, ld_data_i, 1'b0};
                    d.last = FRAME_W'(FRAME_MAX - 1);
                end else begin
                    d.sh   = {2'b11, ld_data_i, 1'b0};
                    d.last = FRAME_W'(FRAME_MAX - 2);
                end
            end
        end else if (tick_i) begin
            if (q.tcnt == OSR_W'(OSR - 1)) begin
                d.tcnt = '0;
                d.sh   = {1'b1, q.sh[FRAME_MAX-1:1]};
                if (q.bits == q.last) d.busy = 1'b0;
                else                  d.bits = q.bits + 1'b1;
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sh   <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign txd_o  = ~q.busy | q.sh[0];
endmodule

// File: rtl/nbit_tx_seq.sv
module nbit_tx_seq
    import nbit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       msg_go_i,
    input  logic [7:0] msg_addr_i,
    input  logic       dat_valid_i,
    input  logic [7:0] dat_byte_i,
    input  logic       dat_last_i,
    input  logic       ser_busy_i,
    output logic       dat_ready_o,
    output logic       ld_o,
    output logic [7:0] ld_data_o,
    output logic       even_sel_o,
    output logic       rts_o
);
    typedef struct packed {
        seq_e              st;
        logic [LEAD_W-1:0] cnt;
        logic [7:0]        addr;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d           = q;
        ld_o        = 1'b0;
        ld_data_o   = q.addr;
        even_sel_o  = 1'b0;
        dat_ready_o = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (msg_go_i) begin
                    d.st   = SQ_LEAD;
                    d.cnt  = '0;
                    d.addr = msg_addr_i;
                end
            end
            SQ_LEAD: begin
                if (tick_i) begin
                    if (q.cnt == LEAD_W'(LEAD_TICKS - 1)) d.st = SQ_ADDR;
                    else                                   d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_ADDR: begin
                if (!ser_busy_i) begin
                    ld_o = 1'b1;
                    d.st = SQ_DATA;
                end
            end
            SQ_DATA: begin
                even_sel_o  = 1'b1;
                ld_data_o   = dat_byte_i;
                dat_ready_o = ~ser_busy_i;
                if (dat_valid_i && !ser_busy_i) begin
                    ld_o = 1'b1;
                    if (dat_last_i) d.st = SQ_TERM;
                end
            end
            SQ_TERM: begin
                ld_data_o = TERM_BYTE;
                if (!ser_busy_i) begin
                    ld_o = 1'b1;
                    d.st = SQ_DRAIN;
                end
            end
            SQ_DRAIN: begin
                if (!ser_busy_i) d.st = SQ_IDLE;
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rts_o = (q.st != SQ_IDLE);
endmodule

// File: rtl/nbit_rx_deser.sv
module nbit_rx_deser
    import nbit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      hold_i,
    input  logic      rxd_i,
    output logic      vld_o,
    output rx_frame_t frame_o
);
    typedef struct packed {
        rxs_e                  st;
        logic [1:0]            sync;
        logic [OSR_W-1:0]      cnt;
        logic [3:0]            idx;
        logic [RX_SAMPLES-1:0] sh;
        logic                  vld;
        rx_frame_t             fr;
    } rx_t;

    rx_t  q, d;
    logic line;

    assign line = q.sync[1];

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.sync = {q.sync[0], rxd_i};
        if (hold_i) begin
            d.st  = RS_IDLE;
            d.cnt = '0;
        end else if (tick_i) begin
            case (q.st)
                RS_IDLE: begin
                    if (!line) begin
                        d.st  = RS_START;
                        d.cnt = '0;
                    end
                end
                RS_START: begin
                    if (q.cnt == OSR_W'(OSR_MID)) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = line ? RS_IDLE : RS_BITS;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RS_BITS: begin
                    if (q.cnt == OSR_W'(OSR - 1)) begin
                        d.cnt = '0;
                        d.sh  = {line, q.sh[RX_SAMPLES-1:1]};
                        if (q.idx == 4'(RX_SAMPLES - 1)) d.st = RS_STOP;
                        else                             d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RS_STOP: begin
                    if (q.cnt == OSR_W'(OSR - 1)) begin
                        d.cnt     = '0;
                        d.vld     = 1'b1;
                        d.fr.data = q.sh[7:0];
                        d.fr.slot = q.sh[8];
                        d.fr.stop = line;
                        d.st      = line ? RS_IDLE : RS_WAITHI;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RS_WAITHI: begin
                    if (line) d.st = RS_IDLE;
                end
                default: d.st = RS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= RS_IDLE;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign vld_o   = q.vld;
    assign frame_o = q.fr;
endmodule

// File: rtl/nbit_bus_uart.sv
module nbit_bus_uart
    import nbit_pkg::*;
#(
    parameter int TICK_DIV = 68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       msg_go,
    input  logic [7:0] msg_addr,
    input  logic       dat_valid,
    input  logic [7:0] dat_byte,
    input  logic       dat_last,
    output logic       dat_ready,
    output logic       txd,
    output logic       rts,
    input  logic       rxd,
    input  logic       filt_en,
    input  logic [7:0] node_addr,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       rx_ninth,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk
);
    logic       tick;
    logic       ser_busy;
    logic       ld;
    logic [7:0] ld_data;
    logic       even_sel;
    logic       fr_vld;
    rx_frame_t  fr;

    nbit_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    nbit_tx_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .msg_go_i    (msg_go),
        .msg_addr_i  (msg_addr),
        .dat_valid_i (dat_valid),
        .dat_byte_i  (dat_byte),
        .dat_last_i  (dat_last),
        .ser_busy_i  (ser_busy),
        .dat_ready_o (dat_ready),
        .ld_o        (ld),
        .ld_data_o   (ld_data),
        .even_sel_o  (even_sel),
        .rts_o       (rts)
    );

    nbit_tx_ser u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .ld_i       (ld),
        .ld_data_i  (ld_data),
        .par_en_i   (1'b1),
        .stick_i    (1'b1),
        .even_sel_i (even_sel),
        .busy_o     (ser_busy),
        .txd_o      (txd)
    );

    nbit_rx_deser u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .hold_i  (rts),
        .rxd_i   (rxd),
        .vld_o   (fr_vld),
        .frame_o (fr)
    );

    typedef struct packed {
        logic       pass;
        logic       valid;
        logic [7:0] data;
        logic       ninth;
        logic       perr;
        logic       ferr;
        logic       brk;
    } out_t;

    out_t q, d;
    logic calc, perr, ninth, deliver;

    always_comb begin
        calc    = ^fr.data;
        perr    = (fr.slot != calc);
        ninth   = perr ? ~calc : calc;
        deliver = 1'b0;
        d       = q;
        d.valid = 1'b0;
        if (fr_vld && !rts) begin
            deliver = !filt_en || (!ninth && q.pass);
            if (ninth) begin
                if (fr.data == TERM_BYTE) d.pass = 1'b0;
                else                      d.pass = (fr.data == node_addr);
            end
            if (deliver) begin
                d.valid = 1'b1;
                d.data  = fr.data;
                d.ninth = ninth;
                d.perr  = perr;
                d.ferr  = ~fr.stop;
                d.brk   = ~fr.stop & ~fr.slot & (fr.data == 8'h00);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_valid = q.valid;
    assign rx_byte  = q.data;
    assign rx_ninth = q.ninth;
    assign rx_perr  = q.perr;
    assign rx_ferr  = q.ferr;
    assign rx_brk   = q.brk;
endmodule

// File: rtl/nbit_bus_uart_chk.sv
module nbit_bus_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       rts,
    input logic       filt_en,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rx_ninth,
    input logic       rx_ferr,
    input logic       rx_brk
);
    a_r4_idle_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rts |-> txd);

    a_r4_no_start_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> txd);

    a_r7_break_implies_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_ferr && rx_byte == 8'h00 && !rx_ninth));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r8_quiet_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (rts && $past(rts)) |-> !rx_valid);

    a_r9_filter_payload_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && filt_en) |-> !rx_ninth);
endmodule

bind nbit_bus_uart nbit_bus_uart_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .rts      (rts),
    .filt_en  (filt_en),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_ninth (rx_ninth),
    .rx_ferr  (rx_ferr),
    .rx_brk   (rx_brk)
);

// File: tb/tb_nbit_bus_uart.sv
`timescale 1ns/1ps
module tb_nbit_bus_uart;
    localparam int TDIV = 2;
    localparam int BIT  = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       msg_go, dat_valid, dat_last, dat_ready;
    logic [7:0] msg_addr, dat_byte;
    logic       txd, rts, rxd, filt_en;
    logic [7:0] node_addr;
    logic       rx_valid, rx_ninth, rx_perr, rx_ferr, rx_brk;
    logic [7:0] rx_byte;

    always #4 clk = ~clk;

    nbit_bus_uart #(.TICK_DIV(TDIV)) dut (
        .clk(clk), .rst_n(rst_n), .msg_go(msg_go), .msg_addr(msg_addr),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_last(dat_last),
        .dat_ready(dat_ready), .txd(txd), .rts(rts), .rxd(rxd),
        .filt_en(filt_en), .node_addr(node_addr), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ninth(rx_ninth), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    int          checks = 0;
    int          errors = 0;
    int          rts_cnt = 0;
    bit          done = 0;
    string       cur_tag = "R10";
    logic [8:0]  txq[$];
    logic [11:0] rxq[$];
    logic [7:0]  mb[4];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) rts_cnt <= rts ? rts_cnt + 1 : 0;

    // Scoreboard driver: transmit message
    task automatic send_msg(input logic [7:0] a, input int n);
        txq.push_back({1'b1, a});
        for (int i = 0; i < n; i++) txq.push_back({1'b0, mb[i]});
        txq.push_back({1'b1, 8'hFF});
        @(negedge clk);
        msg_addr = a;
        msg_go   = 1'b1;
        @(negedge clk);
        msg_go   = 1'b0;
        for (int i = 0; i < n; i++) begin
            dat_byte  = mb[i];
            dat_last  = (i == n - 1);
            dat_valid = 1'b1;
            while (!dat_ready) @(negedge clk);
            @(negedge clk);
            dat_valid = 1'b0;
        end
        while (rts) @(negedge clk);
        repeat (BIT) @(negedge clk);
    endtask

    task automatic expect_rx(input logic [7:0] v, input logic p, input logic s);
        rxq.push_back({v, p, (p != ^v), ~s, (~s & ~p & (v == 8'h00))});
    endtask

    task automatic send_rx(input logic [7:0] v, input logic p, input logic s);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = v[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = p;
        repeat (BIT) @(negedge clk);
        rxd = s;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    // Monitor: transmit line
    initial begin
        logic [8:0] ex;
        logic [7:0] got;
        logic       slot, stp;
        int         n;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && txd === 1'b0) begin
                if (txq.size() == 0) begin
                    chk(0, "R3", "unexpected tx frame", 0, 0);
                    ex = '0;
                end else begin
                    ex = txq.pop_front();
                end
                chk(rts == 1'b1, "R4", "rts at start bit", rts, 1);
                if (ex[8] && ex[7:0] != 8'hFF)
                    chk(rts_cnt >= BIT, "R4", "lead before address", rts_cnt, BIT);
                repeat (BIT / 2) @(negedge clk);
                chk(txd == 1'b0, "R1", "start bit at mid", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BIT) @(negedge clk);
                slot = txd;
                repeat (BIT) @(negedge clk);
                stp = txd;
                chk(got == ex[7:0], "R3", "tx byte order/value", got, ex[7:0]);
                chk(slot == ex[8], "R2", "parity slot flag", slot, ex[8]);
                chk(stp == 1'b1, "R1", "stop bit", stp, 1);
                if (ex == {1'b1, 8'hFF}) begin
                    chk(rts == 1'b1, "R4", "rts held in terminator stop", rts, 1);
                    n = 0;
                    while (rts && n < 4 * BIT) begin
                        @(negedge clk);
                        n++;
                    end
                    chk(n >= BIT / 2 - 2 * TDIV && n <= BIT, "R4", "release delay", n, BIT / 2);
                    chk(txd == 1'b1, "R4", "line idle after release", txd, 1);
                end
            end
        end
    end

    // Monitor: receive outputs
    initial begin
        logic [11:0] ex;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && rx_valid === 1'b1) begin
                if (rxq.size() == 0) begin
                    chk(0, cur_tag, "unexpected rx delivery", rx_byte, 0);
                end else begin
                    ex = rxq.pop_front();
                    chk(rx_byte == ex[11:4], "R5", "rx byte", rx_byte, ex[11:4]);
                    chk(rx_ninth == ex[3], "R6", "ninth bit", rx_ninth, ex[3]);
                    chk(rx_perr == ex[2], "R6", "parity mismatch", rx_perr, ex[2]);
                    chk(rx_ferr == ex[1], "R7", "framing flag", rx_ferr, ex[1]);
                    chk(rx_brk == ex[0], "R7", "break flag", rx_brk, ex[0]);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; msg_go = 1'b0; msg_addr = '0; dat_valid = 1'b0;
        dat_byte = '0; dat_last = 1'b0; rxd = 1'b1; filt_en = 1'b0;
        node_addr = 8'h2C;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(rts == 1'b0, "R10", "rts after reset", rts, 0);
        chk(txd == 1'b1, "R10", "txd after reset", txd, 1);
        chk(rx_valid == 1'b0, "R10", "rx_valid after reset", rx_valid, 0);
        chk(dat_ready == 1'b0, "R10", "dat_ready after reset", dat_ready, 0);

        // R1 R2 R3 R4: messages, incl. payload 0xFF with flag clear
        mb[0] = 8'h01; mb[1] = 8'hC3; mb[2] = 8'h80;
        send_msg(8'h5A, 3);
        mb[0] = 8'hFF;
        send_msg(8'h07, 1);
        chk(txq.size() == 0, "R3", "all tx frames seen", txq.size(), 0);

        // R6 ninth bit recovery, R7 error flags, unfiltered (R9)
        cur_tag = "R9";
        expect_rx(8'h12, 1'b1, 1'b1); send_rx(8'h12, 1'b1, 1'b1);
        expect_rx(8'h34, 1'b0, 1'b1); send_rx(8'h34, 1'b0, 1'b1);
        expect_rx(8'h03, 1'b0, 1'b1); send_rx(8'h03, 1'b0, 1'b1);
        expect_rx(8'h80, 1'b1, 1'b1); send_rx(8'h80, 1'b1, 1'b1);
        expect_rx(8'h55, 1'b0, 1'b0); send_rx(8'h55, 1'b0, 1'b0);
        expect_rx(8'h00, 1'b0, 1'b0); send_rx(8'h00, 1'b0, 1'b0);

        // R5 short low glitch is ignored, then a real frame is received
        cur_tag = "R5";
        @(negedge clk);
        rxd = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk(rxq.size() == 0, "R5", "nothing pending after glitch", rxq.size(), 0);
        expect_rx(8'h3C, 1'b0, 1'b1); send_rx(8'h3C, 1'b0, 1'b1);

        // R9 address filter
        cur_tag = "R9";
        filt_en = 1'b1;
        send_rx(8'h11, 1'b1, 1'b1);
        send_rx(8'h77, 1'b0, 1'b1);
        send_rx(8'h2C, 1'b1, 1'b1);
        expect_rx(8'hA1, 1'b0, 1'b1); send_rx(8'hA1, 1'b0, 1'b1);
        expect_rx(8'h00, 1'b0, 1'b1); send_rx(8'h00, 1'b0, 1'b1);
        send_rx(8'hFF, 1'b1, 1'b1);
        send_rx(8'h99, 1'b0, 1'b1);
        send_rx(8'h2D, 1'b1, 1'b1);
        send_rx(8'h44, 1'b0, 1'b1);
        chk(rxq.size() == 0, "R9", "filtered deliveries complete", rxq.size(), 0);
        filt_en = 1'b0;

        // R8 half duplex: frame arriving while driving is dropped
        cur_tag = "R8";
        mb[0] = 8'h44; mb[1] = 8'h81;
        fork
            send_msg(8'h33, 2);
            begin
                repeat (2 * BIT) @(negedge clk);
                chk(rts == 1'b1, "R8", "driving during injected frame", rts, 1);
                send_rx(8'h5E, 1'b1, 1'b1);
            end
        join
        chk(txq.size() == 0, "R8", "tx unaffected by rx activity", txq.size(), 0);
        expect_rx(8'h66, 1'b0, 1'b1); send_rx(8'h66, 1'b0, 1'b1);
        chk(rxq.size() == 0, "R8", "reception after release", rxq.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule